// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits after instruction decode and before two lockstep integer pipes, a first (primary) pipe and a second (secondary) pipe. Each cycle it is offered up to two decoded instructions: an older one in slot 0 and a younger one in slot 1. It decides whether both can go to the pipes in the same cycle, or whether only the older one goes, to the primary pipe. The instruction supply is told through two take strobes how many instructions were consumed. When only slot 0 is taken, the supply moves the slot 1 instruction into slot 0 for the next cycle.

Each instruction arrives as a compact decode summary: a class code, register masks, flag-write and flag-read bits, and a conditional-branch bit. The general pairing rules are that complex, floating-point, a leading jump, a trailing shift or rotate, and any register dependence all block pairing. Two exceptions override the dependence rule. A flag-setting instruction may pair with a following conditional branch that reads those flags. Two pushes, or two pops, may pair even though both touch the stack pointer. Each single issue is registered with a 3-bit cause code.

Top module: `pair_issue_ctl`

## Requirements
- R1: While reset is asserted, and until the internal synchronized reset releases, take0 and take1 are 0, and u_valid, v_valid and single_why are 0.
- R2: Two valid simple instructions with disjoint register masks and no flag interaction, with both pipes ready, give take0=take1=1 in the same cycle. On the next edge u_valid=v_valid=1 and single_why=0.
- R3: A complex instruction (class 5) in either slot forces single issue with cause 1.
- R4: A floating-point instruction (class 6) in either slot forces single issue with cause 2.
- R5: A jump in slot 0 forces single issue with cause 3. A jump is class 2, or any instruction with its conditional-branch bit set.
- R6: A shift or rotate (class 1) in slot 1 forces single issue with cause 4. The same class in slot 0 still pairs.
- R7: A register dependence forces single issue with cause 5. A dependence exists when slot 0's destination mask overlaps slot 1's source mask or destination mask.
- R8: Flag dependence also gives cause 5. It exists when slot 0 writes flags and slot 1 writes flags, or when slot 0 writes flags and slot 1 reads flags without being a jump. A jump in slot 1 that reads slot 0's flags pairs. This exception does not cover register overlap.
- R9: When both slots are push (class 3), or both are pop (class 4), the stack-pointer bit (index SP_IDX, bit 4 by default) is excluded from the dependence test. Overlap on any other bit, or a push paired with a pop, still gives cause 5.
- R10: A pairable pair with v_ready low gives take0=1, take1=0 and cause 6.
- R11: With u_ready low, or slot 0 not valid, nothing is taken and the registered outputs go to 0.
- R12: A valid slot 0 with slot 1 not valid issues alone with cause 7.
- R13: When several causes apply, the first in this order is reported: slot 0 complex, slot 0 floating-point, slot 0 jump, slot 1 absent, slot 1 complex, slot 1 floating-point, slot 1 shift, dependence, second pipe busy.
- R14: take0 and take1 are combinational in the offer cycle. u_valid, v_valid and single_why reflect that cycle's decision one edge later, with single_why=0 whenever nothing was taken or both were taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s0_valid | input | 1 | Slot 0 (older) instruction present |
| s0_cls | input | 3 | Slot 0 class code |
| s0_dst | input | NREG | Slot 0 destination register mask |
| s0_wflags | input | 1 | Slot 0 writes flags |
| s0_cbr | input | 1 | Slot 0 is a conditional branch |
| s1_valid | input | 1 | Slot 1 (younger) instruction present |
| s1_cls | input | 3 | Slot 1 class code |
| s1_src | input | NREG | Slot 1 source register mask |
| s1_dst | input | NREG | Slot 1 destination register mask |
| s1_rflags | input | 1 | Slot 1 reads flags |
| s1_wflags | input | 1 | Slot 1 writes flags |
| s1_cbr | input | 1 | Slot 1 is a conditional branch |
| u_ready | input | 1 | Primary pipe can accept |
| v_ready | input | 1 | Secondary pipe can accept |
| take0 | output | 1 | Slot 0 consumed this cycle |
| take1 | output | 1 | Slot 1 consumed this cycle |
| u_valid | output | 1 | Registered: primary pipe received an instruction |
| v_valid | output | 1 | Registered: secondary pipe received an instruction |
| single_why | output | 3 | Registered cause of the last single issue |

## Verification
Dependence blocking and the busy second pipe can both apply in the same cycle. So can a leading jump and a complex trailing instruction, and an absent slot 1 and a busy second pipe. The stimulus table holds rows that raise two such causes together, for example a read-after-write pair offered while v_ready is low. Each of these rows is judged by the registered cause, which must be the higher-ranked cause under R13, while take1 stays low. The flag-pair exception is also combined with a register overlap, to confirm that the exception clears only the flag part of the dependence.

// File: rtl/pair_pkg.sv
package pair_pkg;

  typedef enum logic [2:0] {
    CLS_SIMPLE  = 3'd0,
    CLS_SHIFT   = 3'd1,
    CLS_JUMP    = 3'd2,
    CLS_PUSH    = 3'd3,
    CLS_POP     = 3'd4,
    CLS_COMPLEX = 3'd5,
    CLS_FLOAT   = 3'd6
  } op_class_e;

  typedef enum logic [2:0] {
    WHY_NONE    = 3'd0,
    WHY_COMPLEX = 3'd1,
    WHY_FLOAT   = 3'd2,
    WHY_JUMP0   = 3'd3,
    WHY_SHIFT1  = 3'd4,
    WHY_DEPEND  = 3'd5,
    WHY_V_BUSY  = 3'd6,
    WHY_NO_SEC  = 3'd7
  } why_e;

  localparam int N_SLOTS = 2;

endpackage

// File: rtl/pair_slot_screen.sv
module pair_slot_screen
  import pair_pkg::*;
(
  input  logic [2:0] cls,
  input  logic       cbr,
  output logic       is_complex,
  output logic       is_float,
  output logic       is_jump,
  output logic       is_push,
  output logic       is_pop
);

  always_comb begin
    is_complex = (cls == CLS_COMPLEX);
    is_float   = (cls == CLS_FLOAT);
    is_jump    = (cls == CLS_JUMP) | cbr;
    is_push    = (cls == CLS_PUSH);
    is_pop     = (cls == CLS_POP);
  end

endmodule

// File: rtl/pair_dep_check.sv
module pair_dep_check #(
  parameter int NREG   = 8,
  parameter int SP_IDX = 4
) (
  input  logic [NREG-1:0] dst0,
  input  logic [NREG-1:0] src1,
  input  logic [NREG-1:0] dst1,
  input  logic            wf0,
  input  logic            rf1,
  input  logic            wf1,
  input  logic            br1,
  input  logic            same_stack,
  output logic            dep
);

  localparam logic [NREG-1:0] SP_BIT = {{(NREG-1){1'b0}}, 1'b1} << SP_IDX;

  logic [NREG-1:0] keep_mask;
  logic [NREG-1:0] overlap;
  logic            reg_hit;
  logic            flag_hit;

  always_comb begin
    keep_mask = same_stack ? ~SP_BIT : {NREG{1'b1}};
    overlap   = dst0 & (src1 | dst1) & keep_mask;
    reg_hit   = |overlap;
    flag_hit  = wf0 & ((rf1 & ~br1) | wf1);
    dep       = reg_hit | flag_hit;
  end

endmodule

// File: rtl/pair_select.sv
module pair_select
  import pair_pkg::*;
(
  input  logic                live,
  input  logic                v0,
  input  logic                v1,
  input  logic                u_rdy,
  input  logic                v_rdy,
  input  logic [N_SLOTS-1:0]  cpx,
  input  logic [N_SLOTS-1:0]  flt,
  input  logic                jmp0,
  input  logic [2:0]          cls1,
  input  logic                dep,
  output logic                take0,
  output logic                take1,
  output logic [2:0]          why
);

  why_e cause;

  always_comb begin
    if (cpx[0])                    cause = WHY_COMPLEX;
    else if (flt[0])               cause = WHY_FLOAT;
    else if (jmp0)                 cause = WHY_JUMP0;
    else if (!v1)                  cause = WHY_NO_SEC;
    else if (cpx[1])               cause = WHY_COMPLEX;
    else if (flt[1])               cause = WHY_FLOAT;
    else if (cls1 == CLS_SHIFT)    cause = WHY_SHIFT1;
    else if (dep)                  cause = WHY_DEPEND;
    else if (!v_rdy)               cause = WHY_V_BUSY;
    else                           cause = WHY_NONE;
  end

  always_comb begin
    take0 = live & v0 & u_rdy;
    take1 = take0 & (cause == WHY_NONE);
    why   = (take0 & ~take1) ? cause : WHY_NONE;
  end

endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
  import pair_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int SP_IDX = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s0_valid,
  input  logic [2:0]      s0_cls,
  input  logic [NREG-1:0] s0_dst,
  input  logic            s0_wflags,
  input  logic            s0_cbr,
  input  logic            s1_valid,
  input  logic [2:0]      s1_cls,
  input  logic [NREG-1:0] s1_src,
  input  logic [NREG-1:0] s1_dst,
  input  logic            s1_rflags,
  input  logic            s1_wflags,
  input  logic            s1_cbr,
  input  logic            u_ready,
  input  logic            v_ready,
  output logic            take0,
  output logic            take1,
  output logic            u_valid,
  output logic            v_valid,
  output logic [2:0]      single_why
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta;
  logic rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  // Per-slot class screening.
  logic [2:0]         cls_a [N_SLOTS];
  logic [N_SLOTS-1:0] cbr_a;
  logic [N_SLOTS-1:0] cpx;
  logic [N_SLOTS-1:0] flt;
  logic [N_SLOTS-1:0] jmp;
  logic [N_SLOTS-1:0] psh;
  logic [N_SLOTS-1:0] pop;

  assign cls_a[0] = s0_cls;
  assign cls_a[1] = s1_cls;
  assign cbr_a    = {s1_cbr, s0_cbr};

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_screen
    pair_slot_screen u_screen (
      .cls        (cls_a[g]),
      .cbr        (cbr_a[g]),
      .is_complex (cpx[g]),
      .is_float   (flt[g]),
      .is_jump    (jmp[g]),
      .is_push    (psh[g]),
      .is_pop     (pop[g])
    );
  end

  logic same_stack;
  logic dep;

  assign same_stack = (psh[0] & psh[1]) | (pop[0] & pop[1]);

  pair_dep_check #(
    .NREG   (NREG),
    .SP_IDX (SP_IDX)
  ) u_dep (
    .dst0       (s0_dst),
    .src1       (s1_src),
    .dst1       (s1_dst),
    .wf0        (s0_wflags),
    .rf1        (s1_rflags),
    .wf1        (s1_wflags),
    .br1        (jmp[1]),
    .same_stack (same_stack),
    .dep        (dep)
  );

  logic [2:0] why_c;

  pair_select u_sel (
    .live  (rst_ok),
    .v0    (s0_valid),
    .v1    (s1_valid),
    .u_rdy (u_ready),
    .v_rdy (v_ready),
    .cpx   (cpx),
    .flt   (flt),
    .jmp0  (jmp[0]),
    .cls1  (s1_cls),
    .dep   (dep),
    .take0 (take0),
    .take1 (take1),
    .why   (why_c)
  );

  // Issue register stage: next-state and register processes.
  logic       u_q, v_q;
  logic [2:0] why_q;
  logic       u_nx, v_nx;
  logic [2:0] why_nx;
  logic       stage_en;

  always_comb begin
    u_nx     = take0;
    v_nx     = take1;
    why_nx   = why_c;
    stage_en = take0 | u_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      u_q   <= 1'b0;
      v_q   <= 1'b0;
      why_q <= 3'd0;
    end else if (stage_en) begin
      u_q   <= u_nx;
      v_q   <= v_nx;
      why_q <= why_nx;
    end
  end

  assign u_valid    = u_q;
  assign v_valid    = v_q;
  assign single_why = why_q;

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk
  import pair_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] s0_cls,
  input logic       s0_cbr,
  input logic       s0_valid,
  input logic [2:0] s1_cls,
  input logic       u_ready,
  input logic       v_ready,
  input logic       take0,
  input logic       take1,
  input logic       u_valid,
  input logic       v_valid,
  input logic [2:0] single_why
);

  a_r3_complex_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_cls == CLS_COMPLEX || s1_cls == CLS_COMPLEX) |-> !take1);

  a_r4_float_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_cls == CLS_FLOAT || s1_cls == CLS_FLOAT) |-> !take1);

  a_r5_jump_first: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_valid && (s0_cls == CLS_JUMP || s0_cbr)) |-> !take1);

  a_r6_shift_second: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_cls == CLS_SHIFT) |-> !take1);

  a_r10_v_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !v_ready |-> !take1);

  a_r11_u_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!u_ready || !s0_valid) |-> !take0);

  a_r14_u_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take0 |=> u_valid);

  a_r14_u_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take0 |=> !u_valid);

  a_r14_v_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take1 |=> (v_valid && single_why == 3'd0));

  a_r12_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (take0 && !take1) |=> (single_why != 3'd0 && !v_valid));

endmodule

bind pair_issue_ctl pair_issue_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_ok),
  .s0_cls     (s0_cls),
  .s0_cbr     (s0_cbr),
  .s0_valid   (s0_valid),
  .s1_cls     (s1_cls),
  .u_ready    (u_ready),
  .v_ready    (v_ready),
  .take0      (take0),
  .take1      (take1),
  .u_valid    (u_valid),
  .v_valid    (v_valid),
  .single_why (single_why)
);

// File: tb/pair_issue_ctl_bench.sv
module pair_issue_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       s0_valid, s0_wflags, s0_cbr;
  logic [2:0] s0_cls;
  logic [7:0] s0_dst;
  logic       s1_valid, s1_rflags, s1_wflags, s1_cbr;
  logic [2:0] s1_cls;
  logic [7:0] s1_src, s1_dst;
  logic       u_ready, v_ready;
  logic       take0, take1, u_valid, v_valid;
  logic [2:0] single_why;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pair_issue_ctl u_pair_issue_ctl (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_dst(s0_dst),
    .s0_wflags(s0_wflags), .s0_cbr(s0_cbr),
    .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_src(s1_src), .s1_dst(s1_dst),
    .s1_rflags(s1_rflags), .s1_wflags(s1_wflags), .s1_cbr(s1_cbr),
    .u_ready(u_ready), .v_ready(v_ready),
    .take0(take0), .take1(take1), .u_valid(u_valid), .v_valid(v_valid),
    .single_why(single_why)
  );

  typedef struct packed {
    logic       v0; logic [2:0] c0; logic [7:0] d0; logic wf0; logic cb0;
    logic       v1; logic [2:0] c1; logic [7:0] s1; logic [7:0] d1;
    logic       rf1; logic wf1; logic cb1;
    logic       ur; logic vr;
    logic       et0; logic et1; logic [2:0] ew;
    logic [3:0] rq;
  } row_t;

  localparam int NROW = 27;
  // Classes: 0 simple 1 shift 2 jump 3 push 4 pop 5 complex 6 float. SP bit = 8'h10.
  localparam row_t TBL [NROW] = '{
    '{1,0,8'h02,0,0, 1,0,8'h04,8'h08,0,0,0, 1,1, 1,1,0, 2},   // R2 independent pair
    '{1,5,8'h02,0,0, 1,0,8'h04,8'h08,0,0,0, 1,1, 1,0,1, 3},   // R3 complex slot 0
    '{1,0,8'h02,0,0, 1,5,8'h04,8'h08,0,0,0, 1,1, 1,0,1, 3},   // R3 complex slot 1
    '{1,6,8'h02,0,0, 1,0,8'h04,8'h08,0,0,0, 1,1, 1,0,2, 4},   // R4 float slot 0
    '{1,0,8'h02,0,0, 1,6,8'h04,8'h08,0,0,0, 1,1, 1,0,2, 4},   // R4 float slot 1
    '{1,2,8'h00,0,0, 1,0,8'h04,8'h08,0,0,0, 1,1, 1,0,3, 5},   // R5 jump class slot 0
    '{1,0,8'h00,0,1, 1,0,8'h04,8'h08,0,0,0, 1,1, 1,0,3, 5},   // R5 cond-branch bit slot 0
    '{1,0,8'h02,0,0, 1,1,8'h04,8'h08,0,0,0, 1,1, 1,0,4, 6},   // R6 shift slot 1
    '{1,1,8'h02,0,0, 1,0,8'h04,8'h08,0,0,0, 1,1, 1,1,0, 6},   // R6 shift slot 0 pairs
    '{1,0,8'h02,0,0, 1,0,8'h02,8'h08,0,0,0, 1,1, 1,0,5, 7},   // R7 read after write
    '{1,0,8'h02,0,0, 1,0,8'h04,8'h02,0,0,0, 1,1, 1,0,5, 7},   // R7 write after write
    '{1,0,8'h02,1,0, 1,0,8'h04,8'h08,0,1,0, 1,1, 1,0,5, 8},   // R8 both write flags
    '{1,0,8'h02,1,0, 1,2,8'h00,8'h00,1,0,1, 1,1, 1,1,0, 8},   // R8 flag-set + cond branch pairs
    '{1,0,8'h02,1,0, 1,0,8'h04,8'h08,1,0,0, 1,1, 1,0,5, 8},   // R8 flag read by non-branch
    '{1,3,8'h10,0,0, 1,3,8'h12,8'h10,0,0,0, 1,1, 1,1,0, 9},   // R9 push push
    '{1,4,8'h12,0,0, 1,4,8'h10,8'h18,0,0,0, 1,1, 1,1,0, 9},   // R9 pop pop
    '{1,3,8'h10,0,0, 1,4,8'h10,8'h14,0,0,0, 1,1, 1,0,5, 9},   // R9 push then pop
    '{1,4,8'h12,0,0, 1,4,8'h10,8'h12,0,0,0, 1,1, 1,0,5, 9},   // R9 pops same target
    '{1,0,8'h02,0,0, 1,0,8'h04,8'h08,0,0,0, 1,0, 1,0,6, 10},  // R10 second pipe busy
    '{1,0,8'h02,0,0, 1,0,8'h02,8'h08,0,0,0, 1,0, 1,0,5, 13},  // R13 dependence beats busy
    '{1,0,8'h02,0,0, 1,0,8'h04,8'h08,0,0,0, 0,1, 0,0,0, 11},  // R11 primary not ready
    '{0,0,8'h02,0,0, 1,0,8'h04,8'h08,0,0,0, 1,1, 0,0,0, 11},  // R11 slot 0 empty
    '{1,0,8'h02,0,0, 0,0,8'h04,8'h08,0,0,0, 1,1, 1,0,7, 12},  // R12 slot 1 empty
    '{1,2,8'h00,0,0, 1,5,8'h04,8'h08,0,0,0, 1,1, 1,0,3, 13},  // R13 jump0 beats complex1
    '{1,5,8'h02,0,0, 1,6,8'h04,8'h08,0,0,0, 1,1, 1,0,1, 13},  // R13 complex0 beats float1
    '{1,0,8'h02,0,0, 0,0,8'h04,8'h08,0,0,0, 1,0, 1,0,7, 13},  // R13 absent beats busy
    '{1,0,8'h02,1,0, 1,2,8'h02,8'h00,1,0,1, 1,1, 1,0,5, 8}    // R8 branch exception not for regs
  };

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    s0_valid = r.v0; s0_cls = r.c0; s0_dst = r.d0; s0_wflags = r.wf0; s0_cbr = r.cb0;
    s1_valid = r.v1; s1_cls = r.c1; s1_src = r.s1; s1_dst = r.d1;
    s1_rflags = r.rf1; s1_wflags = r.wf1; s1_cbr = r.cb1;
    u_ready = r.ur; v_ready = r.vr;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(TBL[0]);
    #3;
    // R1: outputs cleared and nothing taken during reset.
    chk("R1 take0", int'(take0), 0);
    chk("R1 take1", int'(take1), 0);
    chk("R1 u_valid", int'(u_valid), 0);
    chk("R1 v_valid", int'(v_valid), 0);
    chk("R1 single_why", int'(single_why), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 take0 during sync release", int'(take0), 0);
    repeat (3) @(posedge clk);

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #2;
      chk($sformatf("R%0d row %0d take0", TBL[i].rq, i), int'(take0), int'(TBL[i].et0));
      chk($sformatf("R%0d row %0d take1", TBL[i].rq, i), int'(take1), int'(TBL[i].et1));
      @(posedge clk);
      #2;
      // R14: registered outputs follow the decision one edge later.
      chk($sformatf("R%0d row %0d u_valid", TBL[i].rq, i), int'(u_valid), int'(TBL[i].et0));
      chk($sformatf("R%0d row %0d v_valid", TBL[i].rq, i), int'(v_valid), int'(TBL[i].et1));
      chk($sformatf("R%0d row %0d why", TBL[i].rq, i), int'(single_why), int'(TBL[i].ew));
    end

    // R14: a single issue's cause holds only until the next decision.
    @(negedge clk);
    drive(TBL[1]);
    @(posedge clk);
    #2;
    chk("R14 cause registered", int'(single_why), 1);
    @(negedge clk);
    drive(TBL[0]);
    #1;
    chk("R14 registered value stable before edge", int'(single_why), 1);
    @(posedge clk);
    #2;
    chk("R14 cause cleared after dual", int'(single_why), 0);
    chk("R2 dual after single", int'(v_valid), 1);

    // R1: asynchronous reset clears registered outputs mid-run.
    @(negedge clk);
    drive(TBL[1]);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async clear u_valid", int'(u_valid), 0);
    chk("R1 async clear why", int'(single_why), 0);
    chk("R1 async clear take0", int'(take0), 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

endmodule